// File: doc/BRIEF.md
# Burst-of-Four Dual-Port DDR Word Memory

This block is a synthesizable behavioural model of a synchronous memory with separate data-in and data-out buses. Every access moves a burst of four bus-width beats, one beat per edge of a double-rate beat clock. Each group of two beat edges stands for one main clock cycle. The first edge of each pair, the command slot, stands for the rising edge of the main clock. Read and write commands are sampled only on slot edges, and `cmd_slot` tells the environment which edge comes next.

On the write side, four incoming beats are gathered into one array word four times the bus width. A per-beat active-low lane mask travels with each beat. The array row is updated once, with masked lanes keeping their old contents. On the read side, one array row is fetched and split back into four output beats, marked by `rvalid`. The read and write ports work at the same time. A read always sees every write accepted at its own slot or earlier, including a write to the same row accepted at the very same slot.

Top module: `b4_sram_ddr`

## Requirements
- R1: An array row holds four beats; `rd_addr`/`wr_addr` select a row, and beat b of a burst occupies row bits [b*18 +: 18] with the default parameters.
- R2: A write is accepted on a slot edge when `wr_n` is low and no write burst is in progress; beat 0 is sampled on that edge and beats 1 to 3 on the next three edges.
- R3: `bw_n` is sampled with each write beat; lane 0 is data bits 0 to 8 and lane 1 is bits 9 to 17, and a lane is stored only when its `bw_n` bit is 0; otherwise the row keeps its previous lane contents.
- R4: `cmd_slot` is high exactly when the next beat edge is a slot edge; slot edges alternate, the first edge after reset being one.
- R5: The array row is updated on the third edge after the write's accepting edge, so a read accepted at the following slot returns the new data.
- R6: `rvalid` and beat 0 become visible just after the fifth edge following the read's accepting edge (2.5 main cycles); beats 1 to 3 follow on the next three edges, and `rvalid` is high for exactly those four beats.
- R7: A read returns the row as left by all writes accepted at its own slot edge or earlier, with lane merging, including a write to the same row accepted at the same edge; writes accepted later are not seen.
- R8: A command on a non-slot edge, or on a slot edge while a burst of the same port is still in progress, is ignored.
- R9: `rdata` is all zeros whenever `rvalid` is low.
- R10: Reads accepted on every second slot give an unbroken `rvalid` run with the bursts in order.
- R11: While `rst_n` is low at a clock edge, `rvalid` and `rdata` clear to zero, `cmd_slot` goes high, and any read in flight is dropped.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Beat clock, two edges per main cycle |
| rst_n | input | 1 | Synchronous reset, active low |
| rd_n | input | 1 | Read command, active low |
| rd_addr | input | AW | Read row address |
| wr_n | input | 1 | Write command, active low |
| wr_addr | input | AW | Write row address |
| wdata | input | LANE_W*LANES | Write beat data |
| bw_n | input | LANES | Per-beat lane write enables, active low |
| cmd_slot | output | 1 | High when the next edge samples commands |
| rdata | output | LANE_W*LANES | Read beat data |
| rvalid | output | 1 | Marks beats that carry read data |

## Verification
A read's four beats are due on the fifth to eighth edge after its accepting edge. The bench keeps a reference memory and, when it accepts a read, books the expected beats into a table indexed by those future edge numbers. The write beats of a burst are driven on the accepting edge and the three after it, while junk data and mask values are driven on all other edges. Every output is sampled at the falling edge after each rising edge and compared with the booked entry for that edge, or with zero when none is booked. `cmd_slot` is compared against the bench's own slot parity on every edge.

// File: rtl/b4_sram_pkg.sv
// Shared constants for the burst-of-four word memory.
// Assumes a fixed burst of four beats per access.
package b4_sram_pkg;
    localparam int BEATS      = 4;
    localparam int BEAT_IDX_W = 2;
    // Read fetch happens when the read step counter reaches this value,
    // i.e. on the third edge after the accepting edge.
    localparam int FETCH_STEP = 2;
endpackage

// File: rtl/b4_word_array.sv
// Row storage: one synchronous write port, two combinational read ports.
// Assumes the write side and read side address rows independently.
module b4_word_array #(
    parameter int AW     = 6,
    parameter int WORD_W = 72,
    localparam int DEPTH = 1 << AW
) (
    input  logic              clk,
    input  logic              we,
    input  logic [AW-1:0]     waddr,
    input  logic [WORD_W-1:0] wword,
    input  logic [AW-1:0]     raddr_a,
    output logic [WORD_W-1:0] rword_a,
    input  logic [AW-1:0]     raddr_b,
    output logic [WORD_W-1:0] rword_b
);
    logic [WORD_W-1:0] rows [DEPTH];

    // Store a whole merged row
    always_ff @(posedge clk) begin
        if (we) begin
            rows[waddr] <= wword;
        end
    end

    // Read ports
    assign rword_a = rows[raddr_a];
    assign rword_b = rows[raddr_b];
endmodule

// File: rtl/b4_wr_demux.sv
// Write side: accepts a write on a slot edge, gathers four beats with their
// lane masks and produces one merged row on the edge of the fourth beat.
// Assumes old_word is the current array content of commit_addr.
module b4_wr_demux
    import b4_sram_pkg::*;
#(
    parameter int AW     = 6,
    parameter int LANE_W = 9,
    parameter int LANES  = 2,
    localparam int DW     = LANE_W * LANES,
    localparam int WORD_W = BEATS * DW
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              slot,
    input  logic              wr_n,
    input  logic [AW-1:0]     wr_addr,
    input  logic [DW-1:0]     wdata,
    input  logic [LANES-1:0]  bw_n,
    input  logic [WORD_W-1:0] old_word,
    output logic              accept,
    output logic              commit,
    output logic [AW-1:0]     commit_addr,
    output logic [WORD_W-1:0] commit_word
);
    localparam logic [BEAT_IDX_W-1:0] LAST = BEAT_IDX_W'(BEATS - 1);

    logic                  busy;
    logic [BEAT_IDX_W-1:0] cnt;
    logic [AW-1:0]         addr_q;
    logic                  take;
    logic [BEAT_IDX_W-1:0] cur;
    logic [DW-1:0]         dbuf [BEATS-1];
    logic [LANES-1:0]      mbuf [BEATS-1];
    logic [DW-1:0]         bd   [BEATS];
    logic [LANES-1:0]      bm   [BEATS];

    assign accept      = slot && !wr_n && !busy;
    assign commit      = busy && (cnt == LAST);
    assign commit_addr = addr_q;
    assign take        = accept || (busy && (cnt != LAST));
    assign cur         = accept ? '0 : cnt;

    // Burst progress: busy from the accepting edge to the fourth beat
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy <= 1'b0;
            cnt  <= '0;
        end else if (accept) begin
            busy <= 1'b1;
            cnt  <= BEAT_IDX_W'(1);
        end else if (busy) begin
            cnt <= cnt + 1'b1;
            if (cnt == LAST) begin
                busy <= 1'b0;
            end
        end
    end

    // Latch the row address of the accepted burst
    always_ff @(posedge clk) begin
        if (accept) begin
            addr_q <= wr_addr;
        end
    end

    genvar b, j;
    generate
        for (b = 0; b < BEATS; b++) begin : g_beat
            if (b < BEATS - 1) begin : g_held
                // Hold beat b and its mask until the row is merged
                always_ff @(posedge clk) begin
                    if (take && (cur == BEAT_IDX_W'(b))) begin
                        dbuf[b] <= wdata;
                        mbuf[b] <= bw_n;
                    end
                end
                assign bd[b] = dbuf[b];
                assign bm[b] = mbuf[b];
            end else begin : g_live
                assign bd[b] = wdata;
                assign bm[b] = bw_n;
            end
            for (j = 0; j < LANES; j++) begin : g_lane
                assign commit_word[b*DW + j*LANE_W +: LANE_W] =
                    bm[b][j] ? old_word[b*DW + j*LANE_W +: LANE_W]
                             : bd[b][j*LANE_W +: LANE_W];
            end
        end
    endgenerate

    a_r5_commit_lag: assert property (@(posedge clk) disable iff (!rst_n)
        accept |-> ##3 commit);
endmodule

// File: rtl/b4_rd_fetch.sv
// Read side front end: accepts a read on a slot edge and fetches the row on
// the third edge after it, forwarding a write row committed on that edge.
// Assumes arr_word is the array content of arr_addr.
module b4_rd_fetch
    import b4_sram_pkg::*;
#(
    parameter int AW     = 6,
    parameter int WORD_W = 72
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              slot,
    input  logic              rd_n,
    input  logic [AW-1:0]     rd_addr,
    output logic [AW-1:0]     arr_addr,
    input  logic [WORD_W-1:0] arr_word,
    input  logic              wr_commit,
    input  logic [AW-1:0]     wr_commit_addr,
    input  logic [WORD_W-1:0] wr_commit_word,
    output logic              accept,
    output logic              fetch_v,
    output logic [WORD_W-1:0] fetch_word
);
    localparam logic [BEAT_IDX_W-1:0] STEP = BEAT_IDX_W'(FETCH_STEP);

    logic                  busy;
    logic [BEAT_IDX_W-1:0] cnt;
    logic [AW-1:0]         addr_q;
    logic                  due;

    assign accept   = slot && !rd_n && !busy;
    assign due      = busy && (cnt == STEP);
    assign arr_addr = addr_q;

    // Read progress from the accepting edge to the fetch edge
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy    <= 1'b0;
            cnt     <= '0;
            fetch_v <= 1'b0;
        end else begin
            fetch_v <= due;
            if (accept) begin
                busy <= 1'b1;
                cnt  <= '0;
            end else if (busy) begin
                cnt <= cnt + 1'b1;
                if (due) begin
                    busy <= 1'b0;
                end
            end
        end
    end

    // Latch the read row address
    always_ff @(posedge clk) begin
        if (accept) begin
            addr_q <= rd_addr;
        end
    end

    // Capture the row, taking a same-edge write to the same row first
    always_ff @(posedge clk) begin
        if (due) begin
            fetch_word <= (wr_commit && (wr_commit_addr == addr_q))
                        ? wr_commit_word : arr_word;
        end
    end

    a_r6_fetch_due: assert property (@(posedge clk) disable iff (!rst_n)
        accept |-> ##4 fetch_v);
endmodule

// File: rtl/b4_rd_mux.sv
// Read side back end: holds a fetched row and sends it out as four beats,
// one per edge, with a valid strobe; output data is zero between bursts.
// Assumes fetched rows arrive no more often than once per four edges.
module b4_rd_mux
    import b4_sram_pkg::*;
#(
    parameter int DW = 18,
    localparam int WORD_W = BEATS * DW
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fetch_v,
    input  logic [WORD_W-1:0] fetch_word,
    output logic [DW-1:0]     rdata,
    output logic              rvalid
);
    localparam logic [BEAT_IDX_W-1:0] LAST = BEAT_IDX_W'(BEATS - 1);

    logic [WORD_W-1:0]     ow;
    logic                  oact;
    logic [BEAT_IDX_W-1:0] ocnt;
    logic [DW-1:0]         beats [BEATS];

    genvar g;
    generate
        for (g = 0; g < BEATS; g++) begin : g_split
            assign beats[g] = ow[g*DW +: DW];
        end
    endgenerate

    // Beat sequencer and registered outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ow     <= '0;
            oact   <= 1'b0;
            ocnt   <= '0;
            rdata  <= '0;
            rvalid <= 1'b0;
        end else begin
            rvalid <= oact;
            rdata  <= oact ? beats[ocnt] : '0;
            if (oact) begin
                ocnt <= ocnt + 1'b1;
                if (ocnt == LAST) begin
                    oact <= 1'b0;
                end
            end
            if (fetch_v) begin
                ow   <= fetch_word;
                ocnt <= '0;
                oact <= 1'b1;
            end
        end
    end

    a_r6_valid_lead: assert property (@(posedge clk) disable iff (!rst_n)
        fetch_v |-> ##2 rvalid);
    a_r9_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !rvalid |-> (rdata == '0));
endmodule

// File: rtl/b4_sram_ddr.sv
// Top: burst-of-four word memory with concurrent read and write ports on a
// double-rate beat clock. A phase bit marks slot edges (main clock rising).
// Assumes inputs are synchronous to clk; reset is synchronous, active low.
module b4_sram_ddr
    import b4_sram_pkg::*;
#(
    parameter int AW     = 6,
    parameter int LANE_W = 9,
    parameter int LANES  = 2,
    localparam int DW     = LANE_W * LANES,
    localparam int WORD_W = BEATS * DW
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rd_n,
    input  logic [AW-1:0]    rd_addr,
    input  logic             wr_n,
    input  logic [AW-1:0]    wr_addr,
    input  logic [DW-1:0]    wdata,
    input  logic [LANES-1:0] bw_n,
    output logic             cmd_slot,
    output logic [DW-1:0]    rdata,
    output logic             rvalid
);
    logic              ph;
    logic              wr_acc;
    logic              wr_commit;
    logic [AW-1:0]     wr_caddr;
    logic [WORD_W-1:0] wr_cword;
    logic [WORD_W-1:0] old_word;
    logic              rd_acc;
    logic [AW-1:0]     rd_aaddr;
    logic [WORD_W-1:0] rd_aword;
    logic              fetch_v;
    logic [WORD_W-1:0] fetch_word;

    // Phase bit: 0 means the coming edge is a slot edge
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ph <= 1'b0;
        end else begin
            ph <= ~ph;
        end
    end

    assign cmd_slot = ~ph;

    b4_word_array #(.AW(AW), .WORD_W(WORD_W)) i_array (
        .clk     (clk),
        .we      (wr_commit),
        .waddr   (wr_caddr),
        .wword   (wr_cword),
        .raddr_a (wr_caddr),
        .rword_a (old_word),
        .raddr_b (rd_aaddr),
        .rword_b (rd_aword)
    );

    b4_wr_demux #(.AW(AW), .LANE_W(LANE_W), .LANES(LANES)) i_wr (
        .clk         (clk),
        .rst_n       (rst_n),
        .slot        (cmd_slot),
        .wr_n        (wr_n),
        .wr_addr     (wr_addr),
        .wdata       (wdata),
        .bw_n        (bw_n),
        .old_word    (old_word),
        .accept      (wr_acc),
        .commit      (wr_commit),
        .commit_addr (wr_caddr),
        .commit_word (wr_cword)
    );

    b4_rd_fetch #(.AW(AW), .WORD_W(WORD_W)) i_rdf (
        .clk            (clk),
        .rst_n          (rst_n),
        .slot           (cmd_slot),
        .rd_n           (rd_n),
        .rd_addr        (rd_addr),
        .arr_addr       (rd_aaddr),
        .arr_word       (rd_aword),
        .wr_commit      (wr_commit),
        .wr_commit_addr (wr_caddr),
        .wr_commit_word (wr_cword),
        .accept         (rd_acc),
        .fetch_v        (fetch_v),
        .fetch_word     (fetch_word)
    );

    b4_rd_mux #(.DW(DW)) i_rdm (
        .clk        (clk),
        .rst_n      (rst_n),
        .fetch_v    (fetch_v),
        .fetch_word (fetch_word),
        .rdata      (rdata),
        .rvalid     (rvalid)
    );

    a_r6_read_latency: assert property (@(posedge clk) disable iff (!rst_n)
        rd_acc |-> ##6 rvalid);
    a_r8_wr_gap: assert property (@(posedge clk) disable iff (!rst_n)
        wr_acc |-> ##2 !wr_acc);
    a_r8_rd_gap: assert property (@(posedge clk) disable iff (!rst_n)
        rd_acc |-> ##2 !rd_acc);
endmodule

// File: tb/test_b4_sram_ddr.sv
// Bench: reference memory, booked per-edge expectations, vector table,
// then random overlapping traffic and a reset with a read in flight.
module test_b4_sram_ddr;
    localparam int AW     = 6;
    localparam int LANE_W = 9;
    localparam int LANES  = 2;
    localparam int DW     = LANE_W * LANES;
    localparam int WORD_W = 4 * DW;
    localparam int DEPTH  = 1 << AW;
    localparam int SLOTS  = 4096;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             rd_n = 1'b1;
    logic [AW-1:0]    rd_addr = '0;
    logic             wr_n = 1'b1;
    logic [AW-1:0]    wr_addr = '0;
    logic [DW-1:0]    wdata = '0;
    logic [LANES-1:0] bw_n = '1;
    logic             cmd_slot;
    logic [DW-1:0]    rdata;
    logic             rvalid;

    always #2.5 clk = ~clk;

    b4_sram_ddr #(.AW(AW), .LANE_W(LANE_W), .LANES(LANES)) i_b4_sram_ddr (
        .clk(clk), .rst_n(rst_n), .rd_n(rd_n), .rd_addr(rd_addr),
        .wr_n(wr_n), .wr_addr(wr_addr), .wdata(wdata), .bw_n(bw_n),
        .cmd_slot(cmd_slot), .rdata(rdata), .rvalid(rvalid)
    );

    typedef struct packed {
        logic       rd;
        logic       wr;
        logic [5:0] ra;
        logic [5:0] wa;
        logic [7:0] m;
        logic [3:0] k;
    } vec_t;

    // One entry per slot; the edge after each slot gets junk commands.
    localparam vec_t VEC [18] = '{
        '{1'b0, 1'b1, 6'd0, 6'd1, 8'h00, 4'd1},
        '{1'b1, 1'b1, 6'd1, 6'd2, 8'h00, 4'd3},
        '{1'b1, 1'b1, 6'd3, 6'd1, 8'hA5, 4'd5},
        '{1'b1, 1'b0, 6'd1, 6'd0, 8'h00, 4'd2},
        '{1'b0, 1'b1, 6'd0, 6'd1, 8'h5A, 4'd2},
        '{1'b1, 1'b1, 6'd1, 6'd4, 8'h00, 4'd4},
        '{1'b0, 1'b1, 6'd0, 6'd5, 8'h0F, 4'd1},
        '{1'b1, 1'b1, 6'd5, 6'd5, 8'h00, 4'd5},
        '{1'b0, 1'b0, 6'd0, 6'd0, 8'h00, 4'd0},
        '{1'b1, 1'b1, 6'd6, 6'd6, 8'h33, 4'd4},
        '{1'b0, 1'b0, 6'd0, 6'd0, 8'h00, 4'd0},
        '{1'b1, 1'b1, 6'd6, 6'd7, 8'h00, 4'd2},
        '{1'b0, 1'b0, 6'd0, 6'd0, 8'h00, 4'd0},
        '{1'b1, 1'b1, 6'd7, 6'd7, 8'hF0, 4'd4},
        '{1'b0, 1'b0, 6'd0, 6'd0, 8'h00, 4'd0},
        '{1'b1, 1'b0, 6'd1, 6'd0, 8'h00, 4'd6},
        '{1'b0, 1'b0, 6'd0, 6'd0, 8'h00, 4'd0},
        '{1'b1, 1'b0, 6'd2, 6'd0, 8'h00, 4'd6}
    };

    logic [WORD_W-1:0] ref_mem [DEPTH];
    logic              exp_v [SLOTS];
    logic [DW-1:0]     exp_d [SLOTS];
    string             exp_t [SLOTS];
    logic [DW-1:0]     pw_d [4];
    logic [LANES-1:0]  pw_m [4];
    int  e = 0;
    bit  bslot = 1'b1;
    int  rleft = 0;
    int  wcur = 4;
    int  n_chk = 0;
    int  n_bad = 0;

    function automatic string kind_tag(input logic [3:0] k);
        case (k)
            4'd1:    return "R2";
            4'd2:    return "R3";
            4'd3:    return "R5";
            4'd4:    return "R7";
            4'd5:    return "R8";
            4'd6:    return "R10";
            default: return "R1";
        endcase
    endfunction

    function automatic logic [WORD_W-1:0] rnd_word();
        logic [95:0] t;
        t = {$urandom(), $urandom(), $urandom()};
        return t[WORD_W-1:0];
    endfunction

    task automatic cmp(input string req, input logic [DW-1:0] got,
                       input logic [DW-1:0] want);
        n_chk++;
        if (got !== want) begin
            n_bad++;
            $display("FAIL %s edge %0d: got %h expected %h", req, e, got, want);
        end
    endtask

    task automatic clear_book();
        for (int i = 0; i < SLOTS; i++) begin
            exp_v[i] = 1'b0;
            exp_d[i] = '0;
            exp_t[i] = "R1";
        end
    endtask

    // One beat edge: model acceptance, drive, clock, check outputs.
    task automatic step(input bit rdn, input bit wrn, input logic [AW-1:0] ra,
                        input logic [AW-1:0] wa, input logic [WORD_W-1:0] wword,
                        input logic [7:0] wmask, input string tag);
        bit wacc, racc;
        int ix;
        wacc = bslot && !wrn && (wcur >= 4);
        racc = bslot && !rdn && (rleft == 0);
        if (wacc) begin
            for (int b = 0; b < 4; b++) begin
                pw_d[b] = wword[b*DW +: DW];
                pw_m[b] = wmask[b*LANES +: LANES];
                for (int j = 0; j < LANES; j++) begin
                    if (!pw_m[b][j]) begin
                        ref_mem[wa][b*DW + j*LANE_W +: LANE_W] =
                            pw_d[b][j*LANE_W +: LANE_W];
                    end
                end
            end
            wcur = 0;
        end
        if (racc) begin
            for (int b = 0; b < 4; b++) begin
                ix = (e + 5 + b) % SLOTS;
                exp_v[ix] = 1'b1;
                exp_d[ix] = ref_mem[ra][b*DW +: DW];
                exp_t[ix] = tag;
            end
            rleft = 3;
        end else if (rleft != 0) begin
            rleft--;
        end
        rd_n    = rdn;
        wr_n    = wrn;
        rd_addr = ra;
        wr_addr = wa;
        if (wcur < 4) begin
            wdata = pw_d[wcur];
            bw_n  = pw_m[wcur];
        end else begin
            wdata = DW'($urandom());
            bw_n  = LANES'($urandom());
        end
        @(posedge clk);
        @(negedge clk);
        ix = e % SLOTS;
        cmp("R6", DW'(rvalid), DW'(exp_v[ix]));
        cmp(exp_v[ix] ? exp_t[ix] : "R9", rdata, exp_v[ix] ? exp_d[ix] : '0);
        exp_v[ix] = 1'b0;
        if (wcur < 4) wcur++;
        bslot = !bslot;
        e++;
        cmp("R4", DW'(cmd_slot), DW'(bslot));
    endtask

    // A slot edge followed by an edge carrying junk commands (R8)
    task automatic slot_pair(input bit rd, input bit wr, input logic [AW-1:0] ra,
                             input logic [AW-1:0] wa, input logic [7:0] m,
                             input string tag);
        step(!rd, !wr, ra, wa, rnd_word(), m, tag);
        step(1'b0, 1'b0, AW'($urandom()), AW'($urandom()), rnd_word(),
             8'($urandom()), tag);
    endtask

    task automatic do_reset(input int edges);
        rst_n = 1'b0;
        rd_n  = 1'b1;
        wr_n  = 1'b1;
        for (int i = 0; i < edges; i++) begin
            @(posedge clk);
            @(negedge clk);
        end
        cmp("R11", DW'(rvalid), '0);
        cmp("R11", rdata, '0);
        cmp("R11", DW'(cmd_slot), DW'(1));
        rst_n = 1'b1;
        bslot = 1'b1;
        rleft = 0;
        wcur  = 4;
        clear_book();
    endtask

    initial begin
        clear_book();
        @(negedge clk);
        do_reset(3);

        // Fill every row with full-lane writes (R2)
        for (int a = 0; a < DEPTH; a++) begin
            slot_pair(1'b0, 1'b1, '0, AW'(a), 8'h00, "R2");
            slot_pair(1'b0, 1'b0, '0, '0, 8'h00, "R2");
        end

        // Table walk: directed scenarios
        for (int s = 0; s < 18; s++) begin
            slot_pair(VEC[s].rd, VEC[s].wr, VEC[s].ra, VEC[s].wa, VEC[s].m,
                      kind_tag(VEC[s].k));
        end
        for (int s = 0; s < 6; s++) slot_pair(1'b0, 1'b0, '0, '0, 8'h00, "R9");

        // Random overlapping traffic on a few rows (R1, R7)
        for (int s = 0; s < 300; s++) begin
            slot_pair(($urandom() % 5) < 3, ($urandom() % 5) < 3,
                      AW'($urandom() % 8), AW'($urandom() % 8),
                      8'($urandom()), "R1");
        end
        for (int s = 0; s < 6; s++) slot_pair(1'b0, 1'b0, '0, '0, 8'h00, "R9");

        // Reset with a read in flight drops it (R11)
        slot_pair(1'b1, 1'b0, AW'(3), '0, 8'h00, "R11");
        do_reset(2);
        for (int s = 0; s < 6; s++) slot_pair(1'b0, 1'b0, '0, '0, 8'h00, "R11");

        // After reset: same-edge read and write to one row (R7)
        slot_pair(1'b1, 1'b1, AW'(9), AW'(9), 8'h96, "R7");
        for (int s = 0; s < 6; s++) slot_pair(1'b0, 1'b0, '0, '0, 8'h00, "R9");

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule